// File: doc/BRIEF.md
# Continuation-Heap Fibonacci Engine

This block returns fib(n) for a request number n without a hardware call stack and without an iterative adder loop. The usual doubly recursive definition is replaced by one call register and a heap of continuation records. The call register holds one of two call forms. An evaluate call carries a number and a continuation pointer. An apply call carries a loaded continuation record and a value. On each step the controller dispatches on the call form and on the record kind. Where the step calls for it, the controller pushes a new record into the heap, and the store hands back a fresh pointer. Otherwise it pulls a record back out with a load.

Records come in three kinds: terminal, open (holding n and a parent pointer) and sum (holding a partial result and a parent pointer). A bump allocator hands out heap slots and rewinds to slot zero each time a computation is launched. Slots are never reclaimed during a run, so a run needs 2·fib(n)−1 slots. A request that would need more slots than the heap has ends with an overflow flag instead of a result.

The user places a number on `req_n`, pulses `start` while the engine is not busy, and waits for `done`. `done` and the outputs stay put until the next accepted start.

Top module: `fib_cont_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `ovf`, `res_valid` and `result` are all 0.
- R2: For a request n of 1 or more whose 2·fib(n)−1 records fit the heap, the engine ends with `done`=1, `res_valid`=1, `ovf`=0 and `result`=fib(n), where fib(1)=fib(2)=1. `res_valid` is high only while `done` is high.
- R3: A request of n=0 gives the same outcome as n=1: result 1, valid.
- R4: When a run needs more than 2^HEAP_AW records, the engine ends with `done`=1, `ovf`=1, `res_valid`=0 and `result`=0. It never writes a record once the heap is full. With the default HEAP_AW=8, n=11 (177 records) completes and n=12 (287 records) overflows.
- R5: Every accepted start rewinds the heap allocator to slot 0. Back-to-back runs therefore each get the full heap, including a run that follows an overflow.
- R6: A `start` pulse while `busy` is high has no effect: the running computation finishes with its original request's result.
- R7: After completion, `done`, `result`, `res_valid` and `ovf` hold until the next accepted `start`. That start drops `done` and raises `busy` on the next edge. `busy` and `done` are never high together.
- R8: For n of 2 or less, counting the rising edge that samples `start` as the first, `done` is high after the fifth edge. That path is one edge for the terminal store, one for the dispatch that issues the load, one dedicated load wait state and one apply step. The heap sees at most one access (read or write) per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch pulse, accepted only while not busy |
| req_n | input | VAL_W | Request number n |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Computation finished, outputs valid to read |
| result | output | VAL_W | fib(n) when res_valid is 1, else 0 |
| res_valid | output | 1 | Result is a correct value |
| ovf | output | 1 | Run stopped because the heap was exhausted |

## Verification
On every cycle, the assertions check these rules:
- the heap sees only one access per cycle, and no write once it is full;
- an overflow never comes with a valid result, and a valid result only appears with `done`;
- `busy` and `done` are exclusive, and completed outputs hold until the next start;
- an accepted start leaves the allocator at slot zero.

Only the bench's scenarios can show the rest. That covers the numeric results across several n, n=0 aliasing to n=1, and the exact size at which the heap overflows. It also covers the fixed latency of the base case, ignored starts mid-run, and the allocator rewinding between runs and after an overflow.

// File: rtl/fibk_pkg.sv
package fibk_pkg;

  localparam int unsigned TAG_W = 2;

  // Continuation record kinds stored in the heap tag field
  typedef enum logic [TAG_W-1:0] {
    REC_TERM = 2'd0,
    REC_OPEN = 2'd1,
    REC_SUM  = 2'd2
  } rec_kind_e;

  // Controller states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_EVAL  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_APPLY = 3'd4,
    ST_FIN   = 3'd5
  } eng_state_e;

endpackage

// File: rtl/fibk_heap.sv
module fibk_heap #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  // Synchronous read, one cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= cells[rd_addr];
    end
  end

endmodule

// File: rtl/fibk_alloc.sv
module fibk_alloc #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rewind,
  input  logic          bump,
  output logic [AW-1:0] slot,
  output logic          full
);
  localparam int unsigned CW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [CW-1:0] used_q;
  logic [CW-1:0] used_d;
  logic          used_en;

  always_comb begin
    used_en = rewind | (bump & ~full);
    if (rewind) begin
      used_d = '0;
    end else begin
      used_d = used_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (used_en) begin
      used_q <= used_d;
    end
  end

  assign slot = used_q[AW-1:0];
  assign full = (used_q == CW'(DEPTH));

endmodule

// File: rtl/fibk_ctrl.sv
module fibk_ctrl
  import fibk_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned VAL_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [VAL_W-1:0]              req_n,
  input  logic [AW-1:0]                 heap_slot,
  input  logic                          heap_full,
  input  logic [TAG_W+VAL_W+AW-1:0]     rd_data,
  output logic                          alloc_rewind,
  output logic                          alloc_bump,
  output logic                          wr_en,
  output logic [AW-1:0]                 wr_addr,
  output logic [TAG_W+VAL_W+AW-1:0]     wr_data,
  output logic                          rd_en,
  output logic [AW-1:0]                 rd_addr,
  output logic                          busy,
  output logic                          done,
  output logic [VAL_W-1:0]              result,
  output logic                          res_valid,
  output logic                          ovf
);
  localparam int unsigned REC_W   = TAG_W + VAL_W + AW;
  localparam int unsigned TAG_LSB = VAL_W + AW;

  eng_state_e       state_q, state_d;
  logic [VAL_W-1:0] acc_q, acc_d;      // n for evaluate, value for apply
  logic [AW-1:0]    kptr_q, kptr_d;    // continuation pointer
  rec_kind_e        rkind_q, rkind_d;  // loaded record
  logic [VAL_W-1:0] rval_q, rval_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic             rec_en;
  logic [VAL_W-1:0] res_q, res_d;
  logic             valid_q, valid_d;
  logic             ovf_q, ovf_d;
  logic             out_en;

  logic             idle_like;
  logic             small_n;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_FIN);
  assign small_n   = (acc_q <= VAL_W'(2));

  // Record unpack from heap read port
  always_comb begin
    rkind_d = rec_kind_e'(rd_data[REC_W-1:TAG_LSB]);
    rval_d  = rd_data[AW +: VAL_W];
    rptr_d  = rd_data[AW-1:0];
    rec_en  = (state_q == ST_WAIT);
  end

  // Call dispatch
  always_comb begin
    state_d      = state_q;
    acc_d        = acc_q;
    kptr_d       = kptr_q;
    res_d        = res_q;
    valid_d      = valid_q;
    ovf_d        = ovf_q;
    out_en       = 1'b0;
    alloc_rewind = 1'b0;
    alloc_bump   = 1'b0;
    wr_en        = 1'b0;
    wr_addr      = heap_slot;
    wr_data      = '0;
    rd_en        = 1'b0;
    rd_addr      = kptr_q;

    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          alloc_rewind = 1'b1;
          acc_d        = (req_n == '0) ? VAL_W'(1) : req_n;
          res_d        = '0;
          valid_d      = 1'b0;
          ovf_d        = 1'b0;
          out_en       = 1'b1;
          state_d      = ST_INIT;
        end
      end

      ST_INIT: begin
        wr_en      = 1'b1;
        wr_data    = {REC_TERM, {VAL_W{1'b0}}, {AW{1'b0}}};
        alloc_bump = 1'b1;
        kptr_d     = heap_slot;
        state_d    = ST_EVAL;
      end

      ST_EVAL: begin
        if (small_n) begin
          rd_en   = 1'b1;
          rd_addr = kptr_q;
          acc_d   = VAL_W'(1);
          state_d = ST_WAIT;
        end else if (heap_full) begin
          ovf_d   = 1'b1;
          valid_d = 1'b0;
          res_d   = '0;
          out_en  = 1'b1;
          state_d = ST_FIN;
        end else begin
          wr_en      = 1'b1;
          wr_data    = {REC_OPEN, acc_q, kptr_q};
          alloc_bump = 1'b1;
          kptr_d     = heap_slot;
          acc_d      = acc_q - VAL_W'(1);
        end
      end

      ST_WAIT: begin
        state_d = ST_APPLY;
      end

      ST_APPLY: begin
        unique case (rkind_q)
          REC_TERM: begin
            res_d   = acc_q;
            valid_d = 1'b1;
            out_en  = 1'b1;
            state_d = ST_FIN;
          end
          REC_OPEN: begin
            if (heap_full) begin
              ovf_d   = 1'b1;
              valid_d = 1'b0;
              res_d   = '0;
              out_en  = 1'b1;
              state_d = ST_FIN;
            end else begin
              wr_en      = 1'b1;
              wr_data    = {REC_SUM, acc_q, rptr_q};
              alloc_bump = 1'b1;
              kptr_d     = heap_slot;
              acc_d      = rval_q - VAL_W'(2);
              state_d    = ST_EVAL;
            end
          end
          REC_SUM: begin
            rd_en   = 1'b1;
            rd_addr = rptr_q;
            acc_d   = rval_q + acc_q;
            state_d = ST_WAIT;
          end
          default: begin
            valid_d = 1'b0;
            res_d   = '0;
            out_en  = 1'b1;
            state_d = ST_FIN;
          end
        endcase
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      kptr_q  <= '0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      kptr_q  <= kptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rkind_q <= REC_TERM;
      rval_q  <= '0;
      rptr_q  <= '0;
    end else if (rec_en) begin
      rkind_q <= rkind_d;
      rval_q  <= rval_d;
      rptr_q  <= rptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (out_en) begin
      res_q   <= res_d;
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  assign busy      = ~idle_like;
  assign done      = (state_q == ST_FIN);
  assign result    = res_q;
  assign res_valid = valid_q;
  assign ovf       = ovf_q;

endmodule

// File: rtl/fib_cont_engine.sv
module fib_cont_engine
  import fibk_pkg::*;
#(
  parameter int unsigned HEAP_AW = 8,
  parameter int unsigned VAL_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VAL_W-1:0] req_n,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] result,
  output logic             res_valid,
  output logic             ovf
);
  localparam int unsigned REC_W = TAG_W + VAL_W + HEAP_AW;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic               mem_we;
  logic [HEAP_AW-1:0] mem_waddr;
  logic [REC_W-1:0]   mem_wdata;
  logic               mem_re;
  logic [HEAP_AW-1:0] mem_raddr;
  logic [REC_W-1:0]   mem_rdata;
  logic               alloc_rewind;
  logic               alloc_bump;
  logic [HEAP_AW-1:0] alloc_slot;
  logic               alloc_full;

  fibk_heap #(
    .AW (HEAP_AW),
    .DW (REC_W)
  ) u_heap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata),
    .rd_en   (mem_re),
    .rd_addr (mem_raddr),
    .rd_data (mem_rdata)
  );

  fibk_alloc #(
    .AW (HEAP_AW)
  ) u_alloc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rewind (alloc_rewind),
    .bump   (alloc_bump),
    .slot   (alloc_slot),
    .full   (alloc_full)
  );

  fibk_ctrl #(
    .AW    (HEAP_AW),
    .VAL_W (VAL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start        (start),
    .req_n        (req_n),
    .heap_slot    (alloc_slot),
    .heap_full    (alloc_full),
    .rd_data      (mem_rdata),
    .alloc_rewind (alloc_rewind),
    .alloc_bump   (alloc_bump),
    .wr_en        (mem_we),
    .wr_addr      (mem_waddr),
    .wr_data      (mem_wdata),
    .rd_en        (mem_re),
    .rd_addr      (mem_raddr),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .res_valid    (res_valid),
    .ovf          (ovf)
  );

endmodule

// File: rtl/fibk_checker.sv
module fibk_checker #(
  parameter int unsigned AW    = 8,
  parameter int unsigned VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [VAL_W-1:0] result,
  input logic             res_valid,
  input logic             ovf,
  input logic             mem_we,
  input logic             mem_re,
  input logic [AW-1:0]    alloc_slot,
  input logic             alloc_full
);

  p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !alloc_full);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (!res_valid && done));

  p_valid_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done);

  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result) && $stable(res_valid) && $stable(ovf)));

  p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (alloc_slot == '0 && !alloc_full && busy));

endmodule

bind fib_cont_engine fibk_checker #(
  .AW    (HEAP_AW),
  .VAL_W (VAL_W)
) u_fibk_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .res_valid  (res_valid),
  .ovf        (ovf),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .alloc_slot (alloc_slot),
  .alloc_full (alloc_full)
);

// File: tb/fib_cont_engine_tb.sv
module fib_cont_engine_tb_top;

  localparam int unsigned AW       = 8;
  localparam int unsigned VW       = 16;
  localparam int unsigned DEPTH    = 1 << AW;
  localparam int unsigned NVEC     = 9;
  localparam int unsigned VEC_N [NVEC] = '{0, 1, 2, 3, 5, 7, 10, 11, 12};
  localparam int unsigned RUN_LIMIT = 20000;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [VW-1:0] req_n;
  logic          busy;
  logic          done;
  logic [VW-1:0] result;
  logic          res_valid;
  logic          ovf;

  int checks;
  int fails;

  fib_cont_engine #(
    .HEAP_AW (AW),
    .VAL_W   (VW)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_n     (req_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .res_valid (res_valid),
    .ovf       (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int unsigned fib_ref(input int unsigned n);
    int unsigned a = 1;
    int unsigned b = 1;
    int unsigned t;
    if (n <= 2) return 1;
    for (int unsigned i = 3; i <= n; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse start and wait for done; returns edges counted from the sampling edge
  task automatic launch(input int unsigned n, output int unsigned edges);
    @(negedge clk);
    req_n = VW'(n);
    start = 1'b1;
    edges = 0;
    for (int i = 0; i < RUN_LIMIT; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    req_n = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(!busy && !done && !ovf && !res_valid && result == '0, tag, "idle outputs",
          {busy, done, ovf, res_valid}, 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned edges;
    int unsigned exp_v;
    bit          exp_ovf;
    checks = 0;
    fails  = 0;

    // R1: reset state
    rst_n = 1'b0;
    start = 1'b0;
    req_n = '0;
    #5;
    check_idle("R1");
    do_reset();
    check_idle("R1");

    // R2 R3 R4 R5: vector table, back-to-back runs share the heap only if not rewound
    for (int v = 0; v < NVEC; v++) begin
      exp_v   = fib_ref(VEC_N[v]);
      exp_ovf = (2 * exp_v - 1) > DEPTH;
      launch(VEC_N[v], edges);
      check(done == 1'b1, "R2", "done reached", done, 1);
      if (exp_ovf) begin
        check(ovf && !res_valid && result == '0, "R4", "overflow flags", {ovf, res_valid}, 2);
      end else begin
        check(!ovf && res_valid, (VEC_N[v] == 0) ? "R3" : "R2", "valid", {ovf, res_valid}, 1);
        check(result == VW'(exp_v), (VEC_N[v] == 0) ? "R3" : "R2", "result", result, exp_v);
      end
    end

    // R5: after overflow a new run gets the full heap again, twice
    launch(11, edges);
    check(res_valid && result == VW'(89), "R5", "n=11 after overflow", result, 89);
    launch(11, edges);
    check(res_valid && result == VW'(89), "R5", "n=11 repeated", result, 89);

    // R8: base-case latency
    launch(2, edges);
    check(edges == 5, "R8", "latency n=2", edges, 5);
    launch(0, edges);
    check(edges == 5, "R8", "latency n=0", edges, 5);

    // R7: hold after completion, then restart clears done
    launch(6, edges);
    repeat (6) @(negedge clk);
    check(done && res_valid && result == VW'(8), "R7", "held result", result, 8);
    start = 1'b1;
    req_n = VW'(4);
    @(negedge clk);
    start = 1'b0;
    check(!done && busy, "R7", "restart drops done", {busy, done}, 2);
    for (int i = 0; i < RUN_LIMIT; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(result == VW'(3), "R7", "restart result", result, 3);

    // R6: start while busy ignored
    @(negedge clk);
    req_n = VW'(10);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    req_n = VW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R6", "still busy", busy, 1);
    for (int i = 0; i < RUN_LIMIT; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(result == VW'(55), "R6", "original request result", result, 55);

    // R1: reset in the middle of a run
    @(negedge clk);
    req_n = VW'(11);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    launch(9, edges);
    check(res_valid && result == VW'(34), "R1", "run after mid-run reset", result, 34);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule